// File: doc/BRIEF.md
# Framed SPI Frame-Host Sequencer

This block is the serial engine of an SPI port that runs in framed mode and acts as the frame host. The serial clock never stops. The block sees it as two single-cycle strobes in the system clock domain, one for each rising and one for each falling serial-clock edge. A transfer starts only when the block issues a frame-sync pulse, and it does so only when the one-entry transmit holding register has a word waiting. One pulse opens a frame of a programmable number of characters. The characters are shifted out most-significant bit first, and the bits arriving on the serial input are gathered into receive words.

Configuration sets the character size, the sync polarity, the sync width (one serial-clock period or one whole character), the number of characters per frame and the clock mode bits. The block takes a word from the holding register by pulsing a take strobe. Each completed receive character is presented with a one-cycle done strobe. Configuration is expected to change only while the block is held in reset.

Top module: `framed_spi_host_seq`

## Requirements
- R1: While reset is asserted, fsync_o sits at its inactive level (the inverse of cfg_fs_pol_i), sdo_o is 0, rx_done_o is 0 and rx_data_o is 0.
- R2: When cfg_cpol_i XOR cfg_cpha_i is 1, the transmit edge is the rising strobe and the sample edge is the falling one. Otherwise the roles are swapped. fsync_o and sdo_o change only in the cycle after a transmit-edge strobe.
- R3: While idle, the first transmit edge that finds txh_valid_i high makes fsync_o active and pulses txh_take_o in that same cycle. The first data bit appears on the following transmit edge. txh_take_o is never high without txh_valid_i.
- R4: The active sync level equals cfg_fs_pol_i: 1 gives an active-high pulse and 0 gives an active-low pulse.
- R5: With cfg_fs_char_i = 0 the sync stays active for exactly one transmit edge. With cfg_fs_char_i = 1 it stays active for as many transmit edges as a character has bits.
- R6: cfg_size_i selects the character length: 00 gives 8 bits, 01 gives 16 bits, and 10 or 11 give 32 bits. The low bits of the taken word are sent MSB first, one bit per transmit edge.
- R7: cfg_frm_cnt_i = N makes each sync pulse cover N+1 characters sent back to back, with no other sync pulse inside that frame.
- R8: At the transmit edge after the last bit of a frame, a new sync pulse starts at once if txh_valid_i is high. Otherwise the block goes idle.
- R9: On the sample edge of the last bit of each character, rx_data_o takes the received bits (first bit received in the highest used position, unused upper bits 0) and rx_done_o is high for exactly one cycle.
- R10: If the holding register is empty when a later character of a frame must start, that character is sent as all zeros, nothing is taken, and the frame runs to its full length.
- R11: While idle, sdo_o keeps the last bit driven and fsync_o stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_rise_i | input | 1 | One-cycle strobe marking a rising serial-clock edge |
| sck_fall_i | input | 1 | One-cycle strobe marking a falling serial-clock edge |
| cfg_cpol_i | input | 1 | Clock polarity bit |
| cfg_cpha_i | input | 1 | Clock phase bit |
| cfg_size_i | input | 2 | Character size select |
| cfg_fs_pol_i | input | 1 | Sync active level |
| cfg_fs_char_i | input | 1 | Sync width: 0 for one period, 1 for one character |
| cfg_frm_cnt_i | input | CNT_W | Characters per frame minus one |
| txh_valid_i | input | 1 | Transmit holding register holds a word |
| txh_data_i | input | 32 | Word in the transmit holding register |
| txh_take_o | output | 1 | Holding register word consumed this cycle |
| sdi_i | input | 1 | Serial data in |
| fsync_o | output | 1 | Frame-sync pin |
| sdo_o | output | 1 | Serial data out |
| rx_data_o | output | 32 | Last received character, right-aligned |
| rx_done_o | output | 1 | One-cycle strobe per received character |

## Verification
On every cycle the assertions check the following. Sync and data outputs move only after transmit-edge strobes. The done strobe lasts one cycle and follows a sample edge. A take never happens without a valid word. A new sync pulse never starts sooner than one full frame length after the previous one. The bench's loopback scenarios show what no single-cycle property can: the exact sync pulse shape for each polarity and width, MSB-first bit order for each character size, the back-to-back frame restart, zero fill when the holding register runs dry mid-frame, and the last bit held while idle.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
    localparam int WORD_W = 32;
    localparam int BITS_W = 6;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_SYNC,
        FS_DATA
    } fs_state_e;

    // character length from the size select
    function automatic logic [BITS_W-1:0] char_bits(input logic [1:0] sz);
        case (sz)
            2'b00:   return BITS_W'(8);
            2'b01:   return BITS_W'(16);
            default: return BITS_W'(32);
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] low_mask(input logic [BITS_W-1:0] b);
        if (b >= BITS_W'(WORD_W)) return '1;
        return (WORD_W'(1) << b) - WORD_W'(1);
    endfunction
endpackage

// File: rtl/fsh_edge_sel.sv
module fsh_edge_sel (
    input  logic cpol_i,
    input  logic cpha_i,
    input  logic rise_i,
    input  logic fall_i,
    output logic tx_e_o,
    output logic rx_e_o
);
    logic launch_on_rise;
    assign launch_on_rise = cpol_i ^ cpha_i;
    assign tx_e_o = launch_on_rise ? rise_i : fall_i;
    assign rx_e_o = launch_on_rise ? fall_i : rise_i;
endmodule

// File: rtl/fsh_rx_shift.sv
module fsh_rx_shift
    import fsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_i,
    input  logic              sdi_i,
    input  logic [BITS_W-1:0] bits_i,
    output logic [WORD_W-1:0] word_o,
    output logic              done_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [BITS_W-1:0] cnt;
        logic [WORD_W-1:0] word;
        logic              done;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        if (smp_i) begin
            rx_d.sr = {rx_q.sr[WORD_W-2:0], sdi_i};
            if (rx_q.cnt + BITS_W'(1) == bits_i) begin
                rx_d.word = rx_d.sr & low_mask(bits_i);
                rx_d.done = 1'b1;
                rx_d.cnt  = '0;
            end else begin
                rx_d.cnt = rx_q.cnt + BITS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign word_o = rx_q.word;
    assign done_o = rx_q.done;
endmodule

// File: rtl/framed_spi_host_seq.sv
module framed_spi_host_seq
    import fsh_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              cfg_cpol_i,
    input  logic              cfg_cpha_i,
    input  logic [1:0]        cfg_size_i,
    input  logic              cfg_fs_pol_i,
    input  logic              cfg_fs_char_i,
    input  logic [CNT_W-1:0]  cfg_frm_cnt_i,
    input  logic              txh_valid_i,
    input  logic [WORD_W-1:0] txh_data_i,
    output logic              txh_take_o,
    input  logic              sdi_i,
    output logic              fsync_o,
    output logic              sdo_o,
    output logic [WORD_W-1:0] rx_data_o,
    output logic              rx_done_o
);
    typedef struct packed {
        fs_state_e         st;
        logic [WORD_W-1:0] sr;
        logic              sdo;
        logic              fs_act;
        logic [BITS_W-1:0] fs_left;
        logic [BITS_W-1:0] nbits;
        logic [CNT_W-1:0]  chr;
        logic              pend;
    } seq_t;

    seq_t q, d;

    logic              tx_e, rx_e;
    logic [BITS_W-1:0] bits;
    logic              start;
    logic              take;
    logic [WORD_W-1:0] next_word;
    logic [WORD_W-1:0] aligned;

    fsh_edge_sel u_edge (
        .cpol_i (cfg_cpol_i),
        .cpha_i (cfg_cpha_i),
        .rise_i (sck_rise_i),
        .fall_i (sck_fall_i),
        .tx_e_o (tx_e),
        .rx_e_o (rx_e)
    );

    assign bits = char_bits(cfg_size_i);

    // word for a follow-on character: zero when the holding register is empty
    assign next_word = txh_valid_i ? txh_data_i : '0;
    assign aligned   = next_word << (BITS_W'(WORD_W) - bits);

    always_comb begin
        d     = q;
        start = 1'b0;
        take  = 1'b0;
        if (rx_e) d.pend = 1'b0;
        if (tx_e) begin
            if (q.fs_act) begin
                if (q.fs_left == '0) d.fs_act  = 1'b0;
                else                 d.fs_left = q.fs_left - BITS_W'(1);
            end
            case (q.st)
                FS_IDLE: start = txh_valid_i;
                FS_SYNC: begin
                    d.sdo   = q.sr[WORD_W-1];
                    d.sr    = {q.sr[WORD_W-2:0], 1'b0};
                    d.nbits = BITS_W'(1);
                    d.pend  = 1'b1;
                    d.st    = FS_DATA;
                end
                FS_DATA: begin
                    if (q.nbits != bits) begin
                        d.sdo   = q.sr[WORD_W-1];
                        d.sr    = {q.sr[WORD_W-2:0], 1'b0};
                        d.nbits = q.nbits + BITS_W'(1);
                        d.pend  = 1'b1;
                    end else if (q.chr != cfg_frm_cnt_i) begin
                        d.chr   = q.chr + CNT_W'(1);
                        take    = txh_valid_i;
                        d.sdo   = aligned[WORD_W-1];
                        d.sr    = {aligned[WORD_W-2:0], 1'b0};
                        d.nbits = BITS_W'(1);
                        d.pend  = 1'b1;
                    end else if (txh_valid_i) begin
                        start = 1'b1;
                    end else begin
                        d.st = FS_IDLE;
                    end
                end
                default: d.st = FS_IDLE;
            endcase
            if (start) begin
                take      = 1'b1;
                d.st      = FS_SYNC;
                d.sr      = aligned;
                d.fs_act  = 1'b1;
                d.fs_left = cfg_fs_char_i ? bits - BITS_W'(1) : '0;
                d.chr     = '0;
                d.nbits   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= FS_IDLE;
        end else begin
            q <= d;
        end
    end

    fsh_rx_shift u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_i  (rx_e & q.pend),
        .sdi_i  (sdi_i),
        .bits_i (bits),
        .word_o (rx_data_o),
        .done_o (rx_done_o)
    );

    assign txh_take_o = take;
    assign fsync_o    = q.fs_act ? cfg_fs_pol_i : ~cfg_fs_pol_i;
    assign sdo_o      = q.sdo;
endmodule

// File: rtl/fsh_checker.sv
module fsh_checker
    import fsh_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sck_rise_i,
    input logic             sck_fall_i,
    input logic             cfg_cpol_i,
    input logic             cfg_cpha_i,
    input logic [1:0]       cfg_size_i,
    input logic             cfg_fs_pol_i,
    input logic [CNT_W-1:0] cfg_frm_cnt_i,
    input logic             txh_valid_i,
    input logic             txh_take_o,
    input logic             fsync_o,
    input logic             sdo_o,
    input logic             rx_done_o
);
    localparam int GAP_W = 16;

    logic             tx_edge, rx_edge;
    logic             fs_prev;
    logic             act_obs;
    logic [GAP_W-1:0] gap;
    logic [GAP_W-1:0] frame_len;

    assign tx_edge   = (cfg_cpol_i != cfg_cpha_i) ? sck_rise_i : sck_fall_i;
    assign rx_edge   = (cfg_cpol_i != cfg_cpha_i) ? sck_fall_i : sck_rise_i;
    assign frame_len = GAP_W'(cfg_frm_cnt_i) * GAP_W'(char_bits(cfg_size_i))
                     + GAP_W'(char_bits(cfg_size_i)) + GAP_W'(1);
    assign act_obs   = (fsync_o == cfg_fs_pol_i) && (fs_prev != cfg_fs_pol_i);

    // counts transmit edges since the last observed sync activation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_prev <= ~cfg_fs_pol_i;
            gap     <= '1;
        end else begin
            fs_prev <= fsync_o;
            if (act_obs)                gap <= GAP_W'(tx_edge);
            else if (tx_edge && gap != '1) gap <= gap + GAP_W'(1);
        end
    end

    assert_fsync_on_tx_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_o != $past(fsync_o)) |-> $past(tx_edge));

    assert_sdo_on_tx_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_o != $past(sdo_o)) |-> $past(tx_edge));

    assert_take_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txh_take_o |-> (txh_valid_i && tx_edge));

    assert_single_sync_per_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        act_obs |-> (gap >= frame_len));

    assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o |=> !rx_done_o);

    assert_done_after_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o |-> $past(rx_edge));
endmodule

bind framed_spi_host_seq fsh_checker #(.CNT_W(CNT_W)) u_fsh_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .sck_rise_i    (sck_rise_i),
    .sck_fall_i    (sck_fall_i),
    .cfg_cpol_i    (cfg_cpol_i),
    .cfg_cpha_i    (cfg_cpha_i),
    .cfg_size_i    (cfg_size_i),
    .cfg_fs_pol_i  (cfg_fs_pol_i),
    .cfg_frm_cnt_i (cfg_frm_cnt_i),
    .txh_valid_i   (txh_valid_i),
    .txh_take_o    (txh_take_o),
    .fsync_o       (fsync_o),
    .sdo_o         (sdo_o),
    .rx_done_o     (rx_done_o)
);

// File: tb/framed_spi_host_seq_test.sv
module framed_spi_host_seq_test;
    localparam int CLK_P = 10;
    localparam int CNT_W = 3;
    localparam int NVEC  = 6;
    localparam int LOGN  = 512;

    // {cpol, cpha, size[1:0], pol, wide, cnt[2:0], nwords[3:0], seed[31:0]}
    localparam logic [44:0] VECS [0:NVEC-1] = '{
        {1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 3'd0, 4'd2, 32'hA5C3_1E0F},
        {1'b1, 1'b1, 2'd1, 1'b0, 1'b1, 3'd1, 4'd4, 32'h1234_BEEF},
        {1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 3'd0, 4'd1, 32'hF00D_8001},
        {1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 3'd2, 4'd3, 32'h0F5A_9C36},
        {1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 3'd1, 4'd3, 32'h7E81_44DD},
        {1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 3'd3, 4'd5, 32'hC001_D00D}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rise = 1'b0, fall = 1'b0;
    logic        cpol = 1'b0, cpha = 1'b1;
    logic [1:0]  size = 2'd0;
    logic        pol = 1'b1, wide = 1'b0;
    logic [CNT_W-1:0] fcnt = '0;
    logic [31:0] wq [0:15];
    int          wn = 0;
    int          widx = 0;
    logic        hold_valid;
    logic [31:0] hold_data;
    logic        take, fsync, sdo, rx_done;
    logic [31:0] rx_data;

    int tests = 0, fails = 0;

    logic fs_log [0:LOGN-1];
    logic sdo_log [0:LOGN-1];
    logic [31:0] rx_log [0:15];
    int   n_log = 0, n_rx = 0, offedge = 0, done_run = 0;
    logic log_en = 1'b0;
    logic pfs = 1'b0, psdo = 1'b0, prx = 1'b0;

    assign hold_valid = (widx < wn);
    assign hold_data  = (widx < wn) ? wq[widx] : 32'd0;

    framed_spi_host_seq #(.CNT_W(CNT_W)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sck_rise_i    (rise),
        .sck_fall_i    (fall),
        .cfg_cpol_i    (cpol),
        .cfg_cpha_i    (cpha),
        .cfg_size_i    (size),
        .cfg_fs_pol_i  (pol),
        .cfg_fs_char_i (wide),
        .cfg_frm_cnt_i (fcnt),
        .txh_valid_i   (hold_valid),
        .txh_data_i    (hold_data),
        .txh_take_o    (take),
        .sdi_i         (sdo),
        .fsync_o       (fsync),
        .sdo_o         (sdo),
        .rx_data_o     (rx_data),
        .rx_done_o     (rx_done)
    );

    always #(CLK_P/2) clk = ~clk;

    // free-running serial clock: one rise and one fall strobe every 4 cycles
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            rise = (ph == 0);
            fall = (ph == 2);
            ph = (ph + 1) % 4;
        end
    end

    // holding register model
    initial forever begin
        @(posedge clk);
        if (rst_n && take) widx <= widx + 1;
    end

    // monitor
    initial forever begin
        logic txs;
        @(posedge clk);
        txs = (cpol ^ cpha) ? rise : fall;
        #1;
        if (log_en) begin
            if (txs && n_log < LOGN) begin
                fs_log[n_log]  = fsync;
                sdo_log[n_log] = sdo;
                n_log++;
            end
            if (!txs && (fsync != pfs || sdo != psdo)) offedge++;
            if (rx_done && n_rx < 16) begin rx_log[n_rx] = rx_data; n_rx++; end
            if (rx_done && prx) done_run++;
        end
        pfs = fsync; psdo = sdo; prx = rx_done;
    end

    function automatic logic [31:0] gen(input logic [31:0] seed, input int k);
        return (seed ^ (32'(k) * 32'h9E37_79B9)) + 32'(k);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input int v);
        logic [44:0] e;
        int nw, B, F, frames, L, W, s, start_idx;
        int fs_err, sdo_err, idle_err, rx_err;
        int fs_a, fs_e, sd_a, sd_e, id_a, id_e, rx_a, rx_e2;
        logic [31:0] mask, seed;
        logic lastbit;
        e = VECS[v];
        @(negedge clk);
        rst_n = 1'b0;
        log_en = 1'b0;
        cpol = e[44]; cpha = e[43]; size = e[42:41]; pol = e[40]; wide = e[39];
        fcnt = e[38:36]; nw = int'(e[35:32]); seed = e[31:0];
        wn = 0; widx = 0;
        B = (size == 2'd0) ? 8 : (size == 2'd1) ? 16 : 32;
        F = int'(fcnt) + 1;
        frames = (nw + F - 1) / F;
        L = F * B + 1;
        W = wide ? B : 1;
        mask = (B == 32) ? 32'hFFFF_FFFF : ((32'd1 << B) - 32'd1);
        for (int k = 0; k < 16; k++) wq[k] = gen(seed, k);
        repeat (4) @(negedge clk);
        // R1: reset state
        check(fsync == ~pol && sdo == 1'b0 && rx_done == 1'b0 && rx_data == 32'd0,
              "R1 reset state", int'({fsync, sdo, rx_done}), int'({~pol, 2'b00}));
        n_log = 0; n_rx = 0; offedge = 0; done_run = 0;
        rst_n = 1'b1;
        log_en = 1'b1;
        repeat (13) @(negedge clk);
        start_idx = n_log;
        wn = nw;
        repeat (4 * (frames * L + 10) + 8) @(negedge clk);
        log_en = 1'b0;

        s = -1;
        for (int i = 0; i < n_log; i++) if (s < 0 && fs_log[i] == pol) s = i;
        check(s == start_idx, "R3 sync on first transmit edge with data", s, start_idx);
        if (s < 0) s = 0;

        fs_err = 0; sdo_err = 0; idle_err = 0;
        fs_a = 0; fs_e = 0; sd_a = 0; sd_e = 0; id_a = 0; id_e = 0;
        lastbit = 1'b0;
        for (int i = 0; i < n_log; i++) begin
            logic act_e, bit_e;
            int rel, j, off;
            act_e = 1'b0;
            rel = i - s;
            j = (rel >= 0) ? rel / L : -1;
            if (j >= 0 && j < frames && (rel % L) < W) act_e = 1'b1;
            if (fs_log[i] != (act_e ? pol : ~pol)) begin
                if (fs_err == 0) begin fs_a = int'(fs_log[i]); fs_e = int'(act_e ? pol : ~pol); end
                fs_err++;
            end
            if (rel < 0) begin
                if (sdo_log[i] != 1'b0) begin
                    if (sdo_err == 0) begin sd_a = int'(sdo_log[i]); sd_e = 0; end
                    sdo_err++;
                end
            end else if (j < frames) begin
                off = rel % L;
                if (off != 0) begin
                    int c, b, k;
                    logic [31:0] w;
                    c = (off - 1) / B;
                    b = (off - 1) % B;
                    k = j * F + c;
                    w = (k < nw) ? (wq[k] & mask) : 32'd0;
                    bit_e = w[B - 1 - b];
                    lastbit = bit_e;
                    if (sdo_log[i] != bit_e) begin
                        if (sdo_err == 0) begin sd_a = int'(sdo_log[i]); sd_e = int'(bit_e); end
                        sdo_err++;
                    end
                end
            end else begin
                if (sdo_log[i] != lastbit) begin
                    if (idle_err == 0) begin id_a = int'(sdo_log[i]); id_e = int'(lastbit); end
                    idle_err++;
                end
            end
        end
        check(fs_err == 0, "R4 R5 R7 R8 sync pulse level, width and placement", fs_a, fs_e);
        check(sdo_err == 0, "R6 R10 serial data MSB first with zero fill", sd_a, sd_e);
        check(idle_err == 0 && n_log > s + frames * L, "R11 idle holds last bit", id_a, id_e);

        rx_err = 0; rx_a = 0; rx_e2 = 0;
        for (int k = 0; k < frames * F; k++) begin
            logic [31:0] w;
            w = (k < nw) ? (wq[k] & mask) : 32'd0;
            if (k >= n_rx || rx_log[k] != w) begin
                if (rx_err == 0) begin rx_a = (k < n_rx) ? int'(rx_log[k]) : -1; rx_e2 = int'(w); end
                rx_err++;
            end
        end
        check(rx_err == 0 && n_rx == frames * F, "R9 received words", rx_a, rx_e2);
        check(done_run == 0, "R9 done strobe one cycle", done_run, 0);
        check(widx == nw, "R3 R10 words taken", widx, nw);
        check(offedge == 0, "R2 outputs move only on transmit edge", offedge, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int v = 0; v < NVEC; v++) run_vec(v);

        // directed: holding register empty stays idle (R11) with no take (R3)
        @(negedge clk);
        rst_n = 1'b0; pol = 1'b0; cpol = 1'b0; cpha = 1'b0; wn = 0; widx = 0;
        repeat (3) @(negedge clk);
        check(fsync == 1'b1, "R1 R4 inactive level for active-low sync", int'(fsync), 1);
        rst_n = 1'b1;
        n_log = 0; offedge = 0; log_en = 1'b1;
        repeat (60) @(negedge clk);
        log_en = 1'b0;
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < n_log; i++) if (fs_log[i] != 1'b1 || sdo_log[i] != 1'b0) bad++;
            check(bad == 0 && widx == 0, "R11 R3 no frame without data", bad, 0);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule